// File: doc/BRIEF.md
# Dual-Segment CAN Relay Core

This block is the digital heart of a two-segment CAN transceiver. It joins a local protocol controller, an expansion port used to chain several such blocks, and two physical bus segments, so that every node on either segment sees one logical bus. All digital signals use the bus convention: a low level is dominant and a high level is recessive. A dominant level from either transmit input, or a dominant level received on either enabled segment, is driven onto the segments and reported on the receive outputs.

Each segment has an active-low enable. A disabled segment is never driven, and its received level is read as recessive. The local transmit input also feeds both receive outputs directly. The expansion transmit input feeds only the local receive output, so a chained neighbour never hears its own transmission echoed back. Relaying one segment onto the other would lock both segments dominant forever. To prevent this, reception of a segment is masked while the block drives it dominant, and for a programmable number of clock cycles after that drive ends. The received segment levels pass through a synchronizer before use. The drive requests and the receive outputs are registered.

Top module: `can_dual_relay`

## Requirements
- R1: While `rst_n` is low at a clock edge, all inputs are ignored. Both drive outputs and both receive outputs are high (recessive) after that edge.
- R2: A low level on `tx_local_n` or `tx_exp_n` makes the drive output of every enabled segment low one clock edge later.
- R3: A segment whose enable input is high has its drive output high. Its received level is treated as recessive, whatever the level on the bus.
- R4: A low level received on an enabled, unmasked segment makes the other segment's drive output low, provided that segment is enabled. It also makes both receive outputs low.
- R5: A low `tx_local_n` makes both `rx_local_n` and `rx_exp_n` low one clock edge later, whatever the enables.
- R6: A low `tx_exp_n` makes `rx_local_n` low one edge later. It never makes `rx_exp_n` low, not even through the echo of its own drive on the segments.
- R7: Reception of a segment is masked while its drive output is low, and for `RELEASE_CYCLES` edges after the drive returns high. A masked segment is never relayed. With both transmit inputs high, the two drive outputs are never low together.
- R8: After a single dominant pulse received on segment A ends, both drive outputs return high three edges later and stay high. Both segments are then released.
- R9: When both enabled segments are dominant from outside at once, with no transmit input active, neither segment is driven. Both receive outputs are low.
- R10: A received segment level takes `SYNC_STAGES` edges to reach the relay logic. A relayed drive appears on edge `SYNC_STAGES`+1 after the bus changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tx_local_n | input | 1 | Transmit data from the local controller, low = dominant |
| tx_exp_n | input | 1 | Transmit data from the expansion port, low = dominant |
| seg_a_en_n | input | 1 | Segment A enable, low = enabled |
| seg_b_en_n | input | 1 | Segment B enable, low = enabled |
| seg_a_rx_n | input | 1 | Comparator level of segment A, low = dominant |
| seg_b_rx_n | input | 1 | Comparator level of segment B, low = dominant |
| seg_a_drv_n | output | 1 | Drive request for segment A, low = drive dominant |
| seg_b_drv_n | output | 1 | Drive request for segment B, low = drive dominant |
| rx_local_n | output | 1 | Receive data to the local controller |
| rx_exp_n | output | 1 | Receive data to the expansion port |

## Verification
The hardest situation to reach is the release window. The relayed drive on a segment has just ended, the stale echo is still in the synchronizer, and a genuine dominant then arrives on that same segment. It must stay hidden for exactly the configured number of cycles. The bench models each segment as a wired-AND of the block's own drive and an external node, so the echo comes back through the synchronizer as it would on a real bus. It then starts an external dominant on segment B in the very cycle the relayed drive onto B ends. It checks that segment A is driven on exactly the edge the mask expires, and not one edge earlier.

// File: rtl/can_relay_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the dual-segment relay core.
// Internally, every bus signal is dominant-positive (1 = dominant).
package can_relay_pkg;

    localparam int unsigned SEG_COUNT = 2;
    localparam int unsigned SEG_A     = 0;
    localparam int unsigned SEG_B     = 1;

    typedef logic [SEG_COUNT-1:0] seg_vec_t;

    // Convert an active-low pin level to the internal dominant-positive form.
    function automatic logic pin_to_dom(input logic pin_n);
        return ~pin_n;
    endfunction

endpackage

// File: rtl/can_relay_sync.sv
`timescale 1ns/1ps
// Module: can_relay_sync
// Multi-flop synchronizer for one received segment level.
// Assumes: the input is asynchronous to clk; the reset value is recessive
// (0 in dominant-positive form), so a segment reads idle during reset.
module can_relay_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_dom,
    output logic q_dom
);

    logic [STAGES-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= 1'b0;
                    else        stage_q[s] <= d_dom;
                end
            end else begin : g_next
                // Shift the level one flop further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= 1'b0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_dom = stage_q[STAGES-1];

endmodule

// File: rtl/can_relay_mask.sv
`timescale 1ns/1ps
// Module: can_relay_mask
// Feedback-suppression mask for one segment. The mask is set while the
// segment is driven dominant, and held for RELEASE_CYCLES edges after the
// drive ends, so that the echo still in the synchronizer is not relayed.
// Assumes: RELEASE_CYCLES >= synchronizer depth plus the analog bus delay,
// expressed in clock cycles.
module can_relay_mask #(
    parameter int unsigned RELEASE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_dom,
    output logic mask
);

    localparam int unsigned CNT_W = $clog2(RELEASE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RELEASE_CYCLES);

    logic [CNT_W-1:0] hold_q;

    // Reload while driving; count down to zero once the drive has ended.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hold_q <= '0;
        else if (drive_dom)           hold_q <= CNT_LOAD;
        else if (hold_q != '0)        hold_q <= hold_q - 1'b1;
    end

    // Masked during the drive itself and during the hold window.
    assign mask = drive_dom || (hold_q != '0);

endmodule

// File: rtl/can_relay_route.sv
`timescale 1ns/1ps
// Module: can_relay_route
// Combinational routing between the transmit inputs, the two segments and
// the two receive outputs. All signals are dominant-positive.
// Assumes: en, rx_sync and mask are already aligned to clk.
// Tie rule: a segment is relayed only onto a segment whose own effective
// reception is recessive, so two externally dominant segments never drive
// each other.
module can_relay_route
    import can_relay_pkg::*;
(
    input  seg_vec_t en,
    input  seg_vec_t rx_sync,
    input  seg_vec_t mask,
    input  logic     tx_local_dom,
    input  logic     tx_exp_dom,
    output seg_vec_t drv_next,
    output logic     rx_local_next,
    output logic     rx_exp_next
);

    seg_vec_t rx_eff;
    logic     tx_any;

    // Gate reception with the enable and the feedback mask.
    always_comb begin
        rx_eff = en & rx_sync & ~mask;
        tx_any = tx_local_dom | tx_exp_dom;
    end

    generate
        for (genvar g = 0; g < SEG_COUNT; g++) begin : g_drive
            localparam int unsigned PEER = SEG_COUNT - 1 - g;
            // Drive a segment for transmit data or for relayed peer reception.
            always_comb begin
                drv_next[g] = en[g] & (tx_any | (rx_eff[PEER] & ~rx_eff[g]));
            end
        end
    endgenerate

    // Receive outputs: local sees both transmit inputs, expansion only local.
    always_comb begin
        rx_local_next = tx_any | (|rx_eff);
        rx_exp_next   = tx_local_dom | (|rx_eff);
    end

endmodule

// File: rtl/can_dual_relay.sv
`timescale 1ns/1ps
// Module: can_dual_relay (top)
// Relay core joining a local controller, an expansion port and two CAN
// segments into one logical bus. Pins are active-low (low = dominant).
// Assumes: tx_local_n, tx_exp_n and the enables are synchronous to clk;
// segment levels are asynchronous and are synchronized here.
// Outputs are registered; rst_n is a synchronous power-on reset.
module can_dual_relay
    import can_relay_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned RELEASE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_local_n,
    input  logic tx_exp_n,
    input  logic seg_a_en_n,
    input  logic seg_b_en_n,
    input  logic seg_a_rx_n,
    input  logic seg_b_rx_n,
    output logic seg_a_drv_n,
    output logic seg_b_drv_n,
    output logic rx_local_n,
    output logic rx_exp_n
);

    seg_vec_t en, raw_dom, sync_dom, mask_v, drv_d, drv_q;
    logic     rxl_d, rxe_d, rxl_q, rxe_q;

    // Convert pins to the internal dominant-positive form.
    always_comb begin
        en[SEG_A]      = pin_to_dom(seg_a_en_n);
        en[SEG_B]      = pin_to_dom(seg_b_en_n);
        raw_dom[SEG_A] = pin_to_dom(seg_a_rx_n);
        raw_dom[SEG_B] = pin_to_dom(seg_b_rx_n);
    end

    generate
        for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
            can_relay_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d_dom (raw_dom[g]),
                .q_dom (sync_dom[g])
            );
            can_relay_mask #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_mask (
                .clk       (clk),
                .rst_n     (rst_n),
                .drive_dom (drv_q[g]),
                .mask      (mask_v[g])
            );
        end
    endgenerate

    can_relay_route u_route (
        .en            (en),
        .rx_sync       (sync_dom),
        .mask          (mask_v),
        .tx_local_dom  (pin_to_dom(tx_local_n)),
        .tx_exp_dom    (pin_to_dom(tx_exp_n)),
        .drv_next      (drv_d),
        .rx_local_next (rxl_d),
        .rx_exp_next   (rxe_d)
    );

    // Register drive requests and receive outputs; reset holds them idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
            rxl_q <= 1'b0;
            rxe_q <= 1'b0;
        end else begin
            drv_q <= drv_d;
            rxl_q <= rxl_d;
            rxe_q <= rxe_d;
        end
    end

    assign seg_a_drv_n = ~drv_q[SEG_A];
    assign seg_b_drv_n = ~drv_q[SEG_B];
    assign rx_local_n  = ~rxl_q;
    assign rx_exp_n    = ~rxe_q;

endmodule

// File: rtl/can_relay_chk.sv
`timescale 1ns/1ps
// Module: can_relay_chk
// Port-level properties of can_dual_relay, attached with bind.
module can_relay_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_local_n,
    input logic tx_exp_n,
    input logic seg_a_en_n,
    input logic seg_b_en_n,
    input logic seg_a_drv_n,
    input logic seg_b_drv_n,
    input logic rx_local_n,
    input logic rx_exp_n
);

    logic rst_seen_q;

    // Remember whether the previous edge had reset applied.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1: outputs idle after a reset edge.
    always_comb begin
        if (rst_seen_q === 1'b1) begin
            assert_reset_idle_R1: assert (seg_a_drv_n && seg_b_drv_n && rx_local_n && rx_exp_n)
                else $error("reset did not idle the outputs");
        end
    end

    // R3: a disabled segment is never driven.
    assert_disabled_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seg_a_en_n) |-> seg_a_drv_n);
    assert_disabled_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seg_b_en_n) |-> seg_b_drv_n);

    // R2: local transmit drives an enabled segment one edge later.
    assert_tx_drives_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !tx_local_n && !seg_a_en_n) |-> !seg_a_drv_n);

    // R5: local transmit reaches both receive outputs one edge later.
    assert_tx_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !tx_local_n) |-> (!rx_local_n && !rx_exp_n));

    // R7: without transmit data the two segments are never driven together.
    assert_no_interlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && tx_local_n && tx_exp_n) |-> (seg_a_drv_n || seg_b_drv_n));

endmodule

bind can_dual_relay can_relay_chk u_relay_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_local_n  (tx_local_n),
    .tx_exp_n    (tx_exp_n),
    .seg_a_en_n  (seg_a_en_n),
    .seg_b_en_n  (seg_b_en_n),
    .seg_a_drv_n (seg_a_drv_n),
    .seg_b_drv_n (seg_b_drv_n),
    .rx_local_n  (rx_local_n),
    .rx_exp_n    (rx_exp_n)
);

// File: tb/test_can_dual_relay.sv
`timescale 1ns/1ps
module test_can_dual_relay;

    localparam int unsigned SYNC    = 2;
    localparam int unsigned RELEASE = 8;
    localparam int unsigned NVEC    = 19;

    // Bits: [9] en_a_n [8] en_b_n [7] tx_local_n [6] tx_exp_n [5] ext_a_n
    // [4] ext_b_n | expected [3] bus A [2] bus B [1] rx_local_n [0] rx_exp_n
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0001110000, 10'b0010110001, 10'b0011111111, 10'b0011010000,
        10'b0011100000, 10'b0101110100, 10'b0110110101, 10'b0111010100,
        10'b0111101011, 10'b1001111000, 10'b1010111001, 10'b1011010111,
        10'b1011101000, 10'b1101111100, 10'b1110111101, 10'b1111000011,
        10'b0011000000, 10'b0000110000, 10'b1111111111
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_local_n = 1'b1, tx_exp_n = 1'b1;
    logic seg_a_en_n = 1'b0, seg_b_en_n = 1'b0;
    logic ext_a_n = 1'b1, ext_b_n = 1'b1;
    logic seg_a_drv_n, seg_b_drv_n, rx_local_n, rx_exp_n;
    logic bus_a_n, bus_b_n;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    // Wired-AND segments: the block's drive plus one external node each.
    assign bus_a_n = seg_a_drv_n & ext_a_n;
    assign bus_b_n = seg_b_drv_n & ext_b_n;

    can_dual_relay #(.SYNC_STAGES(SYNC), .RELEASE_CYCLES(RELEASE)) i_can_dual_relay (
        .clk(clk), .rst_n(rst_n),
        .tx_local_n(tx_local_n), .tx_exp_n(tx_exp_n),
        .seg_a_en_n(seg_a_en_n), .seg_b_en_n(seg_b_en_n),
        .seg_a_rx_n(bus_a_n), .seg_b_rx_n(bus_b_n),
        .seg_a_drv_n(seg_a_drv_n), .seg_b_drv_n(seg_b_drv_n),
        .rx_local_n(rx_local_n), .rx_exp_n(rx_exp_n)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_inputs();
        tx_local_n = 1'b1; tx_exp_n = 1'b1; ext_a_n = 1'b1; ext_b_n = 1'b1;
        seg_a_en_n = 1'b0; seg_b_en_n = 1'b0;
    endtask

    initial begin
        // R1: reset ignores active inputs and idles every output.
        @(negedge clk);
        tx_local_n = 1'b0; ext_a_n = 1'b0;
        negs(5);
        chk("R1", "seg_a_drv_n in reset", seg_a_drv_n, 1'b1);
        chk("R1", "seg_b_drv_n in reset", seg_b_drv_n, 1'b1);
        chk("R1", "rx_local_n in reset", rx_local_n, 1'b1);
        chk("R1", "rx_exp_n in reset", rx_exp_n, 1'b1);
        idle_inputs();
        negs(2);
        rst_n = 1'b1;
        negs(4);
        chk("R1", "rx_local_n idle after reset", rx_local_n, 1'b1);

        // Truth table, steady state of each row (R2/R3/R4/R5/R6/R9).
        for (int i = 0; i < NVEC; i++) begin
            logic [9:0] v;
            v = VEC[i];
            seg_a_en_n = v[9]; seg_b_en_n = v[8];
            tx_local_n = v[7]; tx_exp_n = v[6];
            ext_a_n = v[5]; ext_b_n = v[4];
            negs(24);
            chk($sformatf("table row %0d (R2/R3/R4/R5/R6/R9)", i), "bus A", bus_a_n, v[3]);
            chk($sformatf("table row %0d (R2/R3/R4/R5/R6/R9)", i), "bus B", bus_b_n, v[2]);
            chk($sformatf("table row %0d (R2/R3/R4/R5/R6/R9)", i), "rx_local_n", rx_local_n, v[1]);
            chk($sformatf("table row %0d (R2/R3/R4/R5/R6/R9)", i), "rx_exp_n", rx_exp_n, v[0]);
            if (i == 16) begin
                // R9: both segments externally dominant: no relay drive.
                chk("R9", "seg_a_drv_n", seg_a_drv_n, 1'b1);
                chk("R9", "seg_b_drv_n", seg_b_drv_n, 1'b1);
            end
            idle_inputs();
            negs(16);
        end

        // R2 / R5: one-edge latency from local transmit.
        tx_local_n = 1'b0;
        negs(1);
        chk("R2", "seg_a_drv_n after 1 edge", seg_a_drv_n, 1'b0);
        chk("R2", "seg_b_drv_n after 1 edge", seg_b_drv_n, 1'b0);
        chk("R5", "rx_exp_n after 1 edge", rx_exp_n, 1'b0);
        tx_local_n = 1'b1;
        negs(16);

        // R10 / R4 / R7 / R8: single pulse on segment A.
        ext_a_n = 1'b0;
        negs(SYNC);
        chk("R10", "seg_b_drv_n before sync latency", seg_b_drv_n, 1'b1);
        negs(1);
        chk("R10", "seg_b_drv_n after sync latency", seg_b_drv_n, 1'b0);
        chk("R4", "rx_local_n relayed", rx_local_n, 1'b0);
        for (int k = 0; k < 10; k++) begin
            negs(1);
            chk("R7", "echo not relayed to A", seg_a_drv_n, 1'b1);
        end
        ext_a_n = 1'b1;
        negs(SYNC);
        chk("R8", "seg_b_drv_n still driven", seg_b_drv_n, 1'b0);
        negs(1);
        chk("R8", "seg_b_drv_n released", seg_b_drv_n, 1'b1);
        for (int k = 0; k < 30; k++) begin
            negs(1);
            chk("R8", "bus A idle after pulse", bus_a_n, 1'b1);
            chk("R8", "bus B idle after pulse", bus_b_n, 1'b1);
        end
        chk("R8", "rx_exp_n idle after pulse", rx_exp_n, 1'b1);

        // R7: hold window; B goes dominant the edge its relayed drive ends.
        ext_a_n = 1'b0;
        negs(12);
        ext_a_n = 1'b1;
        negs(SYNC + 1);
        chk("R7", "seg_b_drv_n released before hold test", seg_b_drv_n, 1'b1);
        ext_b_n = 1'b0;
        negs(RELEASE);
        chk("R7", "seg_a_drv_n masked in hold window", seg_a_drv_n, 1'b1);
        chk("R7", "rx_local_n masked in hold window", rx_local_n, 1'b1);
        negs(1);
        chk("R7", "seg_a_drv_n after hold window", seg_a_drv_n, 1'b0);
        chk("R7", "rx_local_n after hold window", rx_local_n, 1'b0);
        idle_inputs();
        negs(30);
        chk("R8", "seg_a_drv_n idle at end", seg_a_drv_n, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule